// File: doc/BRIEF.md
# Interrupt Message Acceptance Unit

This block is the receive front of a per-processor interrupt controller. Messages arrive one at a time over a valid/ready port, whether they come from local sources, from the I/O interrupt router or from another processor. Each message carries an 8-bit destination, a flag that selects physical or logical addressing, a 3-bit delivery mode and an 8-bit vector. A message addressed elsewhere is thrown away with no effect.

A message that passes the destination test goes one of two ways. The special modes (NMI, SMI, INIT, external-controller interrupt and startup) are handed directly to the core over a registered valid/ready side channel. The ordinary modes (fixed and lowest-priority) set one bit, chosen by the vector, in a 256-bit pending-request register. The servicing logic clears that register bit by bit. A separate sender path puts outgoing messages onto the bus. If delivery fails, it sends the message again, unless the message is a startup message. It also counts the retries it has made.

Top module: `irq_accept_unit`

## Requirements
- R1: In physical mode (logical flag 0), a message is accepted only when its destination equals `local_id` or is 0xFF. Any other message is taken off the input and leaves the pending register and the core channel unchanged.
- R2: In logical mode (logical flag 1), a message is accepted only when the bitwise AND of its destination and `logical_id` is nonzero.
- R3: An accepted message whose mode is SMI=010, NMI=100, INIT=101, startup=110 or external=111 raises `core_valid` in the next cycle, with the same mode and vector on `core_mode` and `core_vector`. It leaves `req_pend` untouched.
- R4: An accepted message whose mode is fixed=000 or lowest-priority=001 sets bit `req_pend[vector]` in the cycle after acceptance.
- R5: A message with the reserved mode 011 is dropped even when its destination matches.
- R6: While `core_valid` is high and `core_ready` is low, the core outputs hold steady and `in_ready` is low, so no input message is taken.
- R7: A high bit of `req_clr` clears the matching `req_pend` bit on the next edge. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R8: An outgoing message is put on the bus (a one-cycle `bus_valid` pulse) in the cycle after `tx_valid` and `tx_ready` are both high. After a `bus_fail`, a non-startup message is sent again in the very next cycle and `retry_count` increases by one. A `bus_done` ends the transfer and raises `tx_ready` again.
- R9: A startup message (mode 110) that gets `bus_fail` is not sent again. The sender goes idle and `retry_count` does not change.
- R10: After reset, `req_pend` is zero, `core_valid` and `bus_valid` are low, `in_ready` and `tx_ready` are high, and `retry_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_id | input | 8 | Physical ID of this unit |
| logical_id | input | 8 | Logical flat ID of this unit |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Unit can take a message this cycle |
| in_dest | input | 8 | Message destination |
| in_logical | input | 1 | 1 = logical addressing, 0 = physical |
| in_mode | input | 3 | Delivery mode |
| in_vector | input | 8 | Interrupt vector |
| core_valid | output | 1 | Special message offered to the core |
| core_ready | input | 1 | Core takes the offered message |
| core_mode | output | 3 | Mode of the offered message |
| core_vector | output | 8 | Vector of the offered message |
| req_clr | input | 256 | Per-vector clear from servicing logic |
| req_pend | output | 256 | Pending request bits |
| tx_valid | input | 1 | Outgoing message request |
| tx_ready | output | 1 | Sender idle and able to take a message |
| tx_dest | input | 8 | Outgoing destination |
| tx_mode | input | 3 | Outgoing delivery mode |
| tx_vector | input | 8 | Outgoing vector |
| bus_valid | output | 1 | One-cycle send attempt on the bus |
| bus_dest | output | 8 | Destination being sent |
| bus_mode | output | 3 | Mode being sent |
| bus_vector | output | 8 | Vector being sent |
| bus_done | input | 1 | Delivery succeeded |
| bus_fail | input | 1 | Delivery failed |
| retry_count | output | 16 | Saturating count of retries since reset |

## Verification
Physical, broadcast and logical destinations are each sent with IDs that match and with IDs that do not. A logical message whose destination equals the physical ID but shares no bit with the logical ID is included, which tells the two matching rules apart. Every special mode and both ordinary modes are sent, so a routing error shows up as a core offer where a pending bit was expected, or the reverse. The reserved code is sent as well. Input is held back while the core channel is stalled. Clear-only and clear-with-set cycles tell the set-wins rule apart from clear-wins. On the sender side, a failed fixed message is compared with a failed startup message, which shows the startup exemption from retry and the timing of the re-issue.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSVD   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_SIPI   = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    function automatic logic mode_is_direct(input logic [2:0] m);
        return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT) ||
               (m == DM_SIPI) || (m == DM_EXTINT);
    endfunction

    function automatic logic mode_is_pending(input logic [2:0] m);
        return (m == DM_FIXED) || (m == DM_LOWPRI);
    endfunction

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ISSUE = 2'd1,
        TX_WAIT  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic            logical,
    input  logic [ID_W-1:0] phys_id,
    input  logic [ID_W-1:0] log_id,
    output logic            hit
);
    logic phys_hit;
    logic log_hit;

    always_comb begin
        phys_hit = (dest == phys_id) || (dest == {ID_W{1'b1}});
        log_hit  = |(dest & log_id);
        hit      = logical ? log_hit : phys_hit;
    end
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
    parameter int VEC_W = 8,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_idx,
    input  logic [NVEC-1:0]  clr,
    output logic [NVEC-1:0]  pend
);
    logic [NVEC-1:0] set_hot;
    logic [NVEC-1:0] pend_d;
    logic [NVEC-1:0] pend_q;

    for (genvar g = 0; g < NVEC; g++) begin : g_bit
        assign set_hot[g] = set_en && (set_idx == VEC_W'(g));

        // R7: a set always lands, even against a clear of the same bit
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_hot[g] |=> pend_q[g]);
        // R7: a clear without a set empties the bit
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !set_hot[g]) |=> !pend_q[g]);
    end

    always_comb begin
        pend_d = (pend_q & ~clr) | set_hot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_tx_retry.sv
module irq_tx_retry
    import irq_accept_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int VEC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [ID_W-1:0]  tx_dest,
    input  logic [2:0]       tx_mode,
    input  logic [VEC_W-1:0] tx_vector,
    output logic             bus_valid,
    output logic [ID_W-1:0]  bus_dest,
    output logic [2:0]       bus_mode,
    output logic [VEC_W-1:0] bus_vector,
    input  logic             bus_done,
    input  logic             bus_fail,
    output logic [CNT_W-1:0] retry_count
);
    typedef struct packed {
        tx_state_e        st;
        logic [ID_W-1:0]  dest;
        logic [2:0]       mode;
        logic [VEC_W-1:0] vec;
        logic [CNT_W-1:0] cnt;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     fail_retry;

    always_comb begin
        r_d        = r_q;
        fail_retry = 1'b0;
        case (r_q.st)
            TX_IDLE: begin
                if (tx_valid) begin
                    r_d.st   = TX_ISSUE;
                    r_d.dest = tx_dest;
                    r_d.mode = tx_mode;
                    r_d.vec  = tx_vector;
                end
            end
            TX_ISSUE: begin
                r_d.st = TX_WAIT;
            end
            TX_WAIT: begin
                if (bus_fail) begin
                    if (r_q.mode != DM_SIPI) begin
                        fail_retry = 1'b1;
                        r_d.st     = TX_ISSUE;
                        if (r_q.cnt != {CNT_W{1'b1}})
                            r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.st = TX_IDLE;
                    end
                end else if (bus_done) begin
                    r_d.st = TX_IDLE;
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= TX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready    = (r_q.st == TX_IDLE);
    assign bus_valid   = (r_q.st == TX_ISSUE);
    assign bus_dest    = r_q.dest;
    assign bus_mode    = r_q.mode;
    assign bus_vector  = r_q.vec;
    assign retry_count = r_q.cnt;

    // R8: a failed non-startup message goes out again on the next cycle
    a_r8_retry_next: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TX_WAIT && bus_fail && r_q.mode != DM_SIPI) |=> bus_valid);
    // R8: the message contents do not change across a retry
    a_r8_retry_same: assert property (@(posedge clk) disable iff (!rst_n)
        fail_retry |=> ($stable(bus_dest) && $stable(bus_vector) && $stable(bus_mode)));
    // R9: a failed startup message is never sent again
    a_r9_sipi_once: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TX_WAIT && bus_fail && r_q.mode == DM_SIPI)
            |=> (!bus_valid && tx_ready && $stable(retry_count)));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int VEC_W = 8,
    parameter int CNT_W = 16,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  local_id,
    input  logic [ID_W-1:0]  logical_id,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ID_W-1:0]  in_dest,
    input  logic             in_logical,
    input  logic [2:0]       in_mode,
    input  logic [VEC_W-1:0] in_vector,
    output logic             core_valid,
    input  logic             core_ready,
    output logic [2:0]       core_mode,
    output logic [VEC_W-1:0] core_vector,
    input  logic [NVEC-1:0]  req_clr,
    output logic [NVEC-1:0]  req_pend,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [ID_W-1:0]  tx_dest,
    input  logic [2:0]       tx_mode,
    input  logic [VEC_W-1:0] tx_vector,
    output logic             bus_valid,
    output logic [ID_W-1:0]  bus_dest,
    output logic [2:0]       bus_mode,
    output logic [VEC_W-1:0] bus_vector,
    input  logic             bus_done,
    input  logic             bus_fail,
    output logic [CNT_W-1:0] retry_count
);
    typedef struct packed {
        logic             valid;
        logic [2:0]       mode;
        logic [VEC_W-1:0] vec;
    } core_regs_t;

    core_regs_t c_d, c_q;
    logic       dest_hit;
    logic       fire;
    logic       take_direct;
    logic       take_pend;

    irq_dest_match #(.ID_W(ID_W)) i_match (
        .dest    (in_dest),
        .logical (in_logical),
        .phys_id (local_id),
        .log_id  (logical_id),
        .hit     (dest_hit)
    );

    always_comb begin
        in_ready    = !c_q.valid || core_ready;
        fire        = in_valid && in_ready;
        take_direct = fire && dest_hit && mode_is_direct(in_mode);
        take_pend   = fire && dest_hit && mode_is_pending(in_mode);

        c_d = c_q;
        if (c_q.valid && core_ready) c_d.valid = 1'b0;
        if (take_direct) begin
            c_d.valid = 1'b1;
            c_d.mode  = in_mode;
            c_d.vec   = in_vector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign core_valid  = c_q.valid;
    assign core_mode   = c_q.mode;
    assign core_vector = c_q.vec;

    irq_req_reg #(.VEC_W(VEC_W)) i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take_pend),
        .set_idx (in_vector),
        .clr     (req_clr),
        .pend    (req_pend)
    );

    irq_tx_retry #(.ID_W(ID_W), .VEC_W(VEC_W), .CNT_W(CNT_W)) i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_dest     (tx_dest),
        .tx_mode     (tx_mode),
        .tx_vector   (tx_vector),
        .bus_valid   (bus_valid),
        .bus_dest    (bus_dest),
        .bus_mode    (bus_mode),
        .bus_vector  (bus_vector),
        .bus_done    (bus_done),
        .bus_fail    (bus_fail),
        .retry_count (retry_count)
    );

    // R1/R5: a message that is dropped raises no core offer
    a_r1_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !take_direct && !core_valid) |=> !core_valid);
    // R3: a special message is offered to the core on the next cycle
    a_r3_direct_offer: assert property (@(posedge clk) disable iff (!rst_n)
        take_direct |=> (core_valid && core_vector == $past(in_vector)));
    // R3: the direct path and the pending path never fire together
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_direct && take_pend));
    // R6: a stalled offer holds its contents and blocks the input
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !core_ready)
            |=> (core_valid && $stable(core_mode) && $stable(core_vector)));
    a_r6_block: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && !core_ready) |-> !in_ready);
endmodule

// File: tb/test_irq_accept_unit.sv
module test_irq_accept_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   local_id = 8'h12;
    logic [7:0]   logical_id = 8'h0C;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_dest = '0;
    logic         in_logical = 1'b0;
    logic [2:0]   in_mode = '0;
    logic [7:0]   in_vector = '0;
    logic         core_valid;
    logic         core_ready = 1'b0;
    logic [2:0]   core_mode;
    logic [7:0]   core_vector;
    logic [255:0] req_clr = '0;
    logic [255:0] req_pend;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [7:0]   tx_dest = '0;
    logic [2:0]   tx_mode = '0;
    logic [7:0]   tx_vector = '0;
    logic         bus_valid;
    logic [7:0]   bus_dest;
    logic [2:0]   bus_mode;
    logic [7:0]   bus_vector;
    logic         bus_done = 1'b0;
    logic         bus_fail = 1'b0;
    logic [15:0]  retry_count;

    int checks = 0;
    int fails  = 0;
    logic [255:0] exp_pend = '0;

    always #2 clk = ~clk;

    irq_accept_unit i_irq_accept_unit (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] m,
                        input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1; in_dest = d; in_logical = lg; in_mode = m; in_vector = v;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 req_pend", 32'(req_pend == '0), 1);
        check("R10 core_valid", core_valid, 0);
        check("R10 in_ready", in_ready, 1);
        check("R10 tx_ready", tx_ready, 1);
        check("R10 bus_valid", bus_valid, 0);
        check("R10 retry_count", retry_count, 0);
    endtask

    task automatic t_physical();
        send(8'h12, 1'b0, 3'b000, 8'h40); exp_pend[8'h40] = 1'b1;
        check("R4 fixed sets bit 0x40", req_pend[8'h40], 1);
        send(8'h13, 1'b0, 3'b000, 8'h41);
        check("R1 mismatch leaves pend", 32'(req_pend == exp_pend), 1);
        check("R1 mismatch no core", core_valid, 0);
        send(8'hFF, 1'b0, 3'b001, 8'h42); exp_pend[8'h42] = 1'b1;
        check("R1 broadcast lowpri sets", 32'(req_pend == exp_pend), 1);
        send(8'h13, 1'b0, 3'b100, 8'h43);
        check("R1 mismatch NMI no core", core_valid, 0);
    endtask

    task automatic t_logical();
        send(8'h04, 1'b1, 3'b000, 8'h50); exp_pend[8'h50] = 1'b1;
        check("R2 logical overlap sets", 32'(req_pend == exp_pend), 1);
        send(8'h03, 1'b1, 3'b000, 8'h51);
        check("R2 logical disjoint dropped", 32'(req_pend == exp_pend), 1);
        send(8'h12, 1'b1, 3'b000, 8'h52);
        check("R2 logical uses logical id", 32'(req_pend == exp_pend), 1);
    endtask

    task automatic t_direct();
        logic [2:0] modes [5] = '{3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int i = 0; i < 5; i++) begin
            send(8'h12, 1'b0, modes[i], 8'h60 + 8'(i));
            check("R3 core_valid", core_valid, 1);
            check("R3 core_mode", core_mode, modes[i]);
            check("R3 core_vector", core_vector, 8'h60 + 8'(i));
            check("R3 no pend change", 32'(req_pend == exp_pend), 1);
            check("R6 in_ready low", in_ready, 0);
            if (i == 0) begin
                @(negedge clk);
                in_valid = 1'b1; in_dest = 8'h12; in_logical = 1'b0;
                in_mode = 3'b000; in_vector = 8'h70;
                @(negedge clk); @(negedge clk);
                in_valid = 1'b0;
                check("R6 blocked input not taken", req_pend[8'h70], 0);
                check("R6 held vector", core_vector, 8'h60);
                check("R6 held valid", core_valid, 1);
            end
            @(negedge clk); core_ready = 1'b1;
            @(negedge clk); core_ready = 1'b0;
            check("R6 drained", core_valid, 0);
        end
    endtask

    task automatic t_reserved();
        send(8'h12, 1'b0, 3'b011, 8'h71);
        check("R5 reserved no pend", 32'(req_pend == exp_pend), 1);
        check("R5 reserved no core", core_valid, 0);
    endtask

    task automatic t_clear();
        @(negedge clk); req_clr[8'h40] = 1'b1;
        @(negedge clk); req_clr = '0; exp_pend[8'h40] = 1'b0;
        check("R7 clear bit 0x40", 32'(req_pend == exp_pend), 1);
        @(negedge clk);
        req_clr[8'h80] = 1'b1; req_clr[8'h42] = 1'b1;
        in_valid = 1'b1; in_dest = 8'h12; in_logical = 1'b0;
        in_mode = 3'b000; in_vector = 8'h80;
        @(negedge clk);
        in_valid = 1'b0; req_clr = '0;
        exp_pend[8'h80] = 1'b1; exp_pend[8'h42] = 1'b0;
        check("R7 set wins over clear", req_pend[8'h80], 1);
        check("R7 other clear same cycle", 32'(req_pend == exp_pend), 1);
    endtask

    task automatic start_tx(input logic [2:0] m, input logic [7:0] v);
        @(negedge clk);
        tx_valid = 1'b1; tx_mode = m; tx_vector = v; tx_dest = 8'h21;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic t_retry();
        start_tx(3'b000, 8'h90);
        check("R8 first issue", bus_valid, 1);
        check("R8 bus_vector", bus_vector, 8'h90);
        check("R8 busy", tx_ready, 0);
        @(negedge clk);
        check("R8 pulse one cycle", bus_valid, 0);
        bus_fail = 1'b1;
        @(negedge clk); bus_fail = 1'b0;
        check("R8 reissue next cycle", bus_valid, 1);
        check("R8 count one", retry_count, 1);
        check("R8 same dest", bus_dest, 8'h21);
        @(negedge clk); bus_done = 1'b1;
        @(negedge clk); bus_done = 1'b0;
        check("R8 done idles", tx_ready, 1);
        check("R8 no more issue", bus_valid, 0);
    endtask

    task automatic t_sipi();
        start_tx(3'b110, 8'h9A);
        check("R9 first issue", bus_valid, 1);
        @(negedge clk); bus_fail = 1'b1;
        @(negedge clk); bus_fail = 1'b0;
        check("R9 no reissue", bus_valid, 0);
        check("R9 idle", tx_ready, 1);
        check("R9 count unchanged", retry_count, 1);
        @(negedge clk);
        check("R9 still quiet", bus_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_physical();
        t_logical();
        t_direct();
        t_reserved();
        t_clear();
        t_retry();
        t_sipi();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule